// File: doc/BRIEF.md
# Divergence Reconvergence Mask Stack

This block holds, for every warp of a SIMT core, a small stack of saved thread masks and program counters. Because all threads of a warp share one PC, threads that disagree on a branch cannot run both sides at once. When a split request arrives, the block applies the branch predicate to the warp's current thread mask. It returns the mask of threads that follow the taken side and keeps enough state to run the other side later and to merge the threads again.

Each join request pops one entry from that warp's stack. A popped entry can be one of three things. An "else" entry switches the warp to the threads that did not take the branch and redirects the PC to the fall-through address. A "rejoin" entry restores the mask that was in force before the split and lets the warp continue at its next PC. A marker entry, pushed by a split on which all threads agreed, returns the unchanged mask.

Split and join requests carry a warp id. Each is answered one cycle later on its own result channel. The stack depth is a parameter. A split that does not fit is refused and flagged.

Top module: `simt_reconv_stack`

## Requirements
- R1: Synchronous reset empties the stacks of all warps and clears sres_valid, sres_overflow and jres_valid. A join issued after reset, for any warp, gets no response.
- R2: Every split request is answered exactly one cycle later with sres_valid=1 and the same warp id. For a divergent split (at least one active thread with predicate 1 and at least one with predicate 0), sres_mask equals split_mask AND split_pred.
- R3: A split on which all active threads agree (split_mask AND split_pred is zero, or split_mask AND NOT split_pred is zero) returns sres_mask equal to split_mask and pushes one marker entry. The matching join returns jres_mask equal to that split_mask, with jres_redirect=0 and jres_pc=0.
- R4: A divergent split pushes two entries. The first join after it returns jres_mask = split_mask AND NOT split_pred, with jres_redirect=1 and jres_pc = the split_pc of that split.
- R5: The second join after a divergent split returns the original split_mask, with jres_redirect=0 and jres_pc=0.
- R6: Entries of one warp pop in last-in, first-out order, so nested splits unwind innermost first.
- R7: A split that needs more free entries than remain (one for a uniform split, two for a divergent split, with DEPTH entries per warp) sets sres_overflow=1 in its response. It returns sres_mask = split_mask and leaves the stack of that warp unchanged.
- R8: The stacks of different warps are independent. Filling or overflowing one warp has no effect on the capacity or contents of another.
- R9: A join on a warp whose stack is empty gets no response (jres_valid stays 0) and changes nothing.
- R10: A split and a join in the same cycle on different warps are both served. If both name the same warp, the split is served and the join is dropped without a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| split_valid | input | 1 | Split request |
| split_warp | input | WARP_W | Warp of the split |
| split_mask | input | NUM_THREADS | Current thread mask of that warp |
| split_pred | input | NUM_THREADS | Per-thread branch predicate |
| split_pc | input | PC_W | Fall-through PC for the not-taken threads |
| join_valid | input | 1 | Join request |
| join_warp | input | WARP_W | Warp of the join |
| sres_valid | output | 1 | Split response valid |
| sres_warp | output | WARP_W | Warp of the split response |
| sres_mask | output | NUM_THREADS | New thread mask after the split |
| sres_overflow | output | 1 | Split refused: stack lacks room |
| jres_valid | output | 1 | Join response valid |
| jres_warp | output | WARP_W | Warp of the join response |
| jres_mask | output | NUM_THREADS | Thread mask restored by the join |
| jres_redirect | output | 1 | PC must move to jres_pc |
| jres_pc | output | PC_W | Redirect target, zero when no redirect |

## Verification
A split and a join can land in the same cycle. The bench provokes this twice. In the first case a divergent split on one warp is paired with a join on a warp that holds a marker, and both responses are expected in the following cycle. In the second case both requests name the same warp. The split response is expected, and no join response may appear. The later joins on that warp must then unwind exactly the entries the split pushed, which shows that the dropped join popped nothing.

// File: rtl/dstk_pkg.sv
`timescale 1ns/1ps
package dstk_pkg;

    // Kind of a saved stack entry
    typedef enum logic [1:0] {
        ENT_MARK   = 2'd0,   // uniform split, pop returns same mask
        ENT_REJOIN = 2'd1,   // original mask for reconvergence
        ENT_ELSE   = 2'd2    // not-taken threads plus fall-through PC
    } ent_kind_e;

    typedef enum logic {
        SPLIT_UNIFORM = 1'b0,
        SPLIT_DIVERGE = 1'b1
    } split_kind_e;

    // Stack slots consumed by one split of the given kind
    function automatic int slots_needed(split_kind_e k);
        return (k == SPLIT_DIVERGE) ? 2 : 1;
    endfunction

endpackage

// File: rtl/dstk_split_eval.sv
`timescale 1ns/1ps
module dstk_split_eval
    import dstk_pkg::*;
#(
    parameter int NUM_THREADS = 4
) (
    input  logic [NUM_THREADS-1:0] cur_mask,
    input  logic [NUM_THREADS-1:0] pred,
    output logic [NUM_THREADS-1:0] taken_mask,
    output logic [NUM_THREADS-1:0] else_mask,
    output split_kind_e            kind
);

    always_comb begin
        taken_mask = cur_mask & pred;
        else_mask  = cur_mask & ~pred;
        kind       = ((|taken_mask) && (|else_mask)) ? SPLIT_DIVERGE : SPLIT_UNIFORM;
    end

endmodule

// File: rtl/dstk_warp_stack.sv
`timescale 1ns/1ps
module dstk_warp_stack #(
    parameter int ENT_W = 8,
    parameter int DEPTH = 4,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_one,
    input  logic             push_two,
    input  logic             pop,
    input  logic [ENT_W-1:0] ent_lo,   // lower entry (only one when push_one)
    input  logic [ENT_W-1:0] ent_hi,   // upper entry of a double push
    output logic [ENT_W-1:0] top_ent,
    output logic [CNT_W-1:0] count
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [ENT_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0] wr0_idx, wr1_idx, top_idx;

    always_comb begin
        wr0_idx = IDX_W'(count);
        wr1_idx = IDX_W'(count + CNT_W'(1));
        top_idx = IDX_W'(count - CNT_W'(1));
        top_ent = mem[top_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (push_two) begin
            mem[wr0_idx] <= ent_lo;
            mem[wr1_idx] <= ent_hi;
            count        <= count + CNT_W'(2);
        end else if (push_one) begin
            mem[wr0_idx] <= ent_lo;
            count        <= count + CNT_W'(1);
        end else if (pop) begin
            count        <= count - CNT_W'(1);
        end
    end

endmodule

// File: rtl/simt_reconv_stack.sv
`timescale 1ns/1ps
module simt_reconv_stack
    import dstk_pkg::*;
#(
    parameter int NUM_WARPS   = 4,
    parameter int NUM_THREADS = 4,
    parameter int DEPTH       = 4,
    parameter int PC_W        = 16,
    parameter int WARP_W      = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   split_valid,
    input  logic [WARP_W-1:0]      split_warp,
    input  logic [NUM_THREADS-1:0] split_mask,
    input  logic [NUM_THREADS-1:0] split_pred,
    input  logic [PC_W-1:0]        split_pc,
    input  logic                   join_valid,
    input  logic [WARP_W-1:0]      join_warp,
    output logic                   sres_valid,
    output logic [WARP_W-1:0]      sres_warp,
    output logic [NUM_THREADS-1:0] sres_mask,
    output logic                   sres_overflow,
    output logic                   jres_valid,
    output logic [WARP_W-1:0]      jres_warp,
    output logic [NUM_THREADS-1:0] jres_mask,
    output logic                   jres_redirect,
    output logic [PC_W-1:0]        jres_pc
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        ent_kind_e              kind;
        logic [NUM_THREADS-1:0] mask;
        logic [PC_W-1:0]        pc;
    } ent_t;

    localparam int ENT_W = $bits(ent_t);

    // Split classification
    logic [NUM_THREADS-1:0] taken_mask, else_mask;
    split_kind_e            skind;

    dstk_split_eval #(.NUM_THREADS(NUM_THREADS)) u_eval (
        .cur_mask   (split_mask),
        .pred       (split_pred),
        .taken_mask (taken_mask),
        .else_mask  (else_mask),
        .kind       (skind)
    );

    // Per-warp stacks
    logic [NUM_WARPS-1:0][CNT_W-1:0] cnt_all;
    logic [ENT_W-1:0]                top_all [NUM_WARPS];
    logic [NUM_WARPS-1:0]            push_one_w, push_two_w, pop_w;
    ent_t                            ent_lo, ent_hi;

    // Request decode
    logic       split_ovf, split_ok, join_ok, same_warp;
    ent_t       join_top;

    always_comb begin
        same_warp = split_valid && join_valid && (split_warp == join_warp);
        split_ovf = split_valid &&
                    ((int'(cnt_all[split_warp]) + slots_needed(skind)) > DEPTH);
        split_ok  = split_valid && !split_ovf;
        join_ok   = join_valid && !same_warp && (cnt_all[join_warp] != '0);
        join_top  = ent_t'(top_all[join_warp]);

        if (skind == SPLIT_DIVERGE) begin
            ent_lo = '{kind: ENT_REJOIN, mask: split_mask, pc: split_pc};
            ent_hi = '{kind: ENT_ELSE,   mask: else_mask,  pc: split_pc};
        end else begin
            ent_lo = '{kind: ENT_MARK,   mask: split_mask, pc: split_pc};
            ent_hi = '{kind: ENT_MARK,   mask: split_mask, pc: split_pc};
        end
    end

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
        always_comb begin
            push_two_w[w] = split_ok && (split_warp == WARP_W'(w)) && (skind == SPLIT_DIVERGE);
            push_one_w[w] = split_ok && (split_warp == WARP_W'(w)) && (skind == SPLIT_UNIFORM);
            pop_w[w]      = join_ok  && (join_warp  == WARP_W'(w));
        end

        dstk_warp_stack #(
            .ENT_W (ENT_W),
            .DEPTH (DEPTH),
            .CNT_W (CNT_W)
        ) u_stk (
            .clk      (clk),
            .rst      (rst),
            .push_one (push_one_w[w]),
            .push_two (push_two_w[w]),
            .pop      (pop_w[w]),
            .ent_lo   (ent_lo),
            .ent_hi   (ent_hi),
            .top_ent  (top_all[w]),
            .count    (cnt_all[w])
        );
    end

    // Registered responses
    always_ff @(posedge clk) begin
        if (rst) begin
            sres_valid    <= 1'b0;
            sres_warp     <= '0;
            sres_mask     <= '0;
            sres_overflow <= 1'b0;
            jres_valid    <= 1'b0;
            jres_warp     <= '0;
            jres_mask     <= '0;
            jres_redirect <= 1'b0;
            jres_pc       <= '0;
        end else begin
            sres_valid    <= split_valid;
            sres_warp     <= split_warp;
            sres_overflow <= split_ovf;
            sres_mask     <= (split_ovf || skind == SPLIT_UNIFORM) ? split_mask : taken_mask;

            jres_valid    <= join_ok;
            jres_warp     <= join_warp;
            jres_mask     <= join_top.mask;
            jres_redirect <= (join_top.kind == ENT_ELSE);
            jres_pc       <= (join_top.kind == ENT_ELSE) ? join_top.pc : '0;
        end
    end

endmodule

// File: rtl/dstk_checker.sv
`timescale 1ns/1ps
module dstk_checker #(
    parameter int NUM_WARPS   = 4,
    parameter int NUM_THREADS = 4,
    parameter int DEPTH       = 4,
    parameter int WARP_W      = 2,
    parameter int CNT_W       = 3
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            split_valid,
    input logic [WARP_W-1:0]               split_warp,
    input logic [NUM_THREADS-1:0]          split_mask,
    input logic                            join_valid,
    input logic [WARP_W-1:0]               join_warp,
    input logic                            sres_valid,
    input logic [NUM_THREADS-1:0]          sres_mask,
    input logic                            sres_overflow,
    input logic                            jres_valid,
    input logic [NUM_WARPS-1:0][CNT_W-1:0] cnt_all
);

    logic [WARP_W-1:0] last_sw;
    logic [CNT_W-1:0]  last_cnt;

    always_ff @(posedge clk) begin
        last_sw  <= split_warp;
        last_cnt <= cnt_all[split_warp];
    end

    // R2: each split answered in the next cycle
    a_r2_split_answered: assert property (@(posedge clk) disable iff (rst)
        split_valid |=> sres_valid);

    // R2: new mask never enables a thread outside the incoming mask
    a_r2_mask_subset: assert property (@(posedge clk) disable iff (rst)
        sres_valid |-> ((sres_mask & ~$past(split_mask)) == '0));

    // R7: refused split hands back the incoming mask
    a_r7_overflow_mask: assert property (@(posedge clk) disable iff (rst)
        sres_overflow |-> (sres_mask == $past(split_mask)));

    // R7: refused split leaves its warp's stack depth alone
    a_r7_overflow_no_push: assert property (@(posedge clk) disable iff (rst)
        sres_overflow |-> (cnt_all[last_sw] == last_cnt));

    // R9: join on an empty stack stays silent
    a_r9_empty_join: assert property (@(posedge clk) disable iff (rst)
        (join_valid && cnt_all[join_warp] == '0) |=> !jres_valid);

    // R10: join colliding with a split on the same warp is dropped
    a_r10_same_warp_drop: assert property (@(posedge clk) disable iff (rst)
        (split_valid && join_valid && split_warp == join_warp) |=> !jres_valid);

    // R7: no stack ever holds more than DEPTH entries
    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_bound
        a_r7_depth_bound: assert property (@(posedge clk) disable iff (rst)
            cnt_all[w] <= CNT_W'(DEPTH));
    end

endmodule

bind simt_reconv_stack dstk_checker #(
    .NUM_WARPS   (NUM_WARPS),
    .NUM_THREADS (NUM_THREADS),
    .DEPTH       (DEPTH),
    .WARP_W      (WARP_W),
    .CNT_W       (CNT_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .split_valid   (split_valid),
    .split_warp    (split_warp),
    .split_mask    (split_mask),
    .join_valid    (join_valid),
    .join_warp     (join_warp),
    .sres_valid    (sres_valid),
    .sres_mask     (sres_mask),
    .sres_overflow (sres_overflow),
    .jres_valid    (jres_valid),
    .cnt_all       (cnt_all)
);

// File: tb/sim_simt_reconv_stack.sv
`timescale 1ns/1ps
module sim_simt_reconv_stack;

    localparam int NW = 4;
    localparam int NT = 4;
    localparam int D  = 4;
    localparam int PW = 16;
    localparam int WW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          split_valid = 1'b0;
    logic [WW-1:0] split_warp = '0;
    logic [NT-1:0] split_mask = '0;
    logic [NT-1:0] split_pred = '0;
    logic [PW-1:0] split_pc = '0;
    logic          join_valid = 1'b0;
    logic [WW-1:0] join_warp = '0;
    logic          sres_valid, sres_overflow, jres_valid, jres_redirect;
    logic [WW-1:0] sres_warp, jres_warp;
    logic [NT-1:0] sres_mask, jres_mask;
    logic [PW-1:0] jres_pc;

    always #2 clk = ~clk;

    simt_reconv_stack #(
        .NUM_WARPS(NW), .NUM_THREADS(NT), .DEPTH(D), .PC_W(PW)
    ) u0 (
        .clk(clk), .rst(rst),
        .split_valid(split_valid), .split_warp(split_warp),
        .split_mask(split_mask), .split_pred(split_pred), .split_pc(split_pc),
        .join_valid(join_valid), .join_warp(join_warp),
        .sres_valid(sres_valid), .sres_warp(sres_warp), .sres_mask(sres_mask),
        .sres_overflow(sres_overflow),
        .jres_valid(jres_valid), .jres_warp(jres_warp), .jres_mask(jres_mask),
        .jres_redirect(jres_redirect), .jres_pc(jres_pc)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Bench model of the stacks: kind 0 marker, 1 rejoin, 2 else
    int      m_cnt  [NW];
    int      m_kind [NW][D];
    int      m_mask [NW][D];
    int      m_pc   [NW][D];

    // Expected response queues
    int    sq_warp[$], sq_mask[$], sq_ovf[$];
    string sq_tag[$];
    int    jq_warp[$], jq_mask[$], jq_redir[$], jq_pc[$];
    string jq_tag[$];

    task automatic model_push(int w, int k, int mk, int pc);
        m_kind[w][m_cnt[w]] = k;
        m_mask[w][m_cnt[w]] = mk;
        m_pc[w][m_cnt[w]]   = pc;
        m_cnt[w]++;
    endtask

    // One request cycle; either side may be idle
    task automatic step(bit sv, int sw, int mk, int pd, int pc,
                        bit jv, int jw, string stag, string jtag);
        int taken, other, need;
        bit div;
        @(negedge clk);
        split_valid = sv;
        split_warp  = WW'(sw);
        split_mask  = NT'(mk);
        split_pred  = NT'(pd);
        split_pc    = PW'(pc);
        join_valid  = jv;
        join_warp   = WW'(jw);
        if (jv && !(sv && sw == jw) && m_cnt[jw] > 0) begin
            int t;
            m_cnt[jw]--;
            t = m_cnt[jw];
            jq_warp.push_back(jw);
            jq_mask.push_back(m_mask[jw][t]);
            jq_redir.push_back(m_kind[jw][t] == 2 ? 1 : 0);
            jq_pc.push_back(m_kind[jw][t] == 2 ? m_pc[jw][t] : 0);
            jq_tag.push_back(jtag);
        end
        if (sv) begin
            taken = mk & pd;
            other = mk & ~pd & ((1 << NT) - 1);
            div   = (taken != 0) && (other != 0);
            need  = div ? 2 : 1;
            sq_warp.push_back(sw);
            sq_tag.push_back(stag);
            if (m_cnt[sw] + need > D) begin
                sq_mask.push_back(mk);
                sq_ovf.push_back(1);
            end else begin
                sq_ovf.push_back(0);
                if (div) begin
                    model_push(sw, 1, mk, pc);
                    model_push(sw, 2, other, pc);
                    sq_mask.push_back(taken);
                end else begin
                    model_push(sw, 0, mk, pc);
                    sq_mask.push_back(mk);
                end
            end
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            split_valid = 1'b0;
            join_valid  = 1'b0;
        end
    endtask

    task automatic split(int w, int mk, int pd, int pc, string tag);
        step(1, w, mk, pd, pc, 0, 0, tag, "");
    endtask

    task automatic jn(int w, string tag);
        step(0, 0, 0, 0, 0, 1, w, "", tag);
    endtask

    // Monitor: compares responses against the queues
    always @(posedge clk) begin
        #1;
        if (!rst && !done) begin
            if (sres_valid) begin
                checks++;
                if (sq_warp.size() == 0) begin
                    errors++;
                    $display("FAIL unexpected split response: warp=%0d mask=%h expected none",
                             sres_warp, sres_mask);
                end else begin
                    int ew, em, eo;
                    string tg;
                    ew = sq_warp.pop_front(); em = sq_mask.pop_front();
                    eo = sq_ovf.pop_front();  tg = sq_tag.pop_front();
                    if (int'(sres_warp) != ew || int'(sres_mask) != em || int'(sres_overflow) != eo) begin
                        errors++;
                        $display("FAIL %s split: warp=%0d mask=%h ovf=%0d expected warp=%0d mask=%h ovf=%0d",
                                 tg, sres_warp, sres_mask, sres_overflow, ew, em, eo);
                    end
                end
            end
            if (jres_valid) begin
                checks++;
                if (jq_warp.size() == 0) begin
                    errors++;
                    $display("FAIL R9 unexpected join response: warp=%0d mask=%h expected none",
                             jres_warp, jres_mask);
                end else begin
                    int ew, em, er, ep;
                    string tg;
                    ew = jq_warp.pop_front(); em = jq_mask.pop_front();
                    er = jq_redir.pop_front(); ep = jq_pc.pop_front();
                    tg = jq_tag.pop_front();
                    if (int'(jres_warp) != ew || int'(jres_mask) != em ||
                        int'(jres_redirect) != er || int'(jres_pc) != ep) begin
                        errors++;
                        $display("FAIL %s join: warp=%0d mask=%h redir=%0d pc=%h expected warp=%0d mask=%h redir=%0d pc=%h",
                                 tg, jres_warp, jres_mask, jres_redirect, jres_pc, ew, em, er, ep);
                    end
                end
            end
        end
    end

    task automatic check_drained(string tag);
        checks++;
        if (sq_warp.size() != 0 || jq_warp.size() != 0) begin
            errors++;
            $display("FAIL %s: pending split=%0d join=%0d expected 0 0",
                     tag, sq_warp.size(), jq_warp.size());
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        split_valid = 1'b0;
        join_valid  = 1'b0;
        for (int w = 0; w < NW; w++) m_cnt[w] = 0;
        idle(2);
        checks++;
        if (sres_valid || sres_overflow || jres_valid) begin
            errors++;
            $display("FAIL R1 reset outputs: sv=%0d ovf=%0d jv=%0d expected 0 0 0",
                     sres_valid, sres_overflow, jres_valid);
        end
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        for (int w = 0; w < NW; w++) m_cnt[w] = 0;
        do_reset();

        // R1 / R9: all stacks empty after reset
        for (int w = 0; w < NW; w++) jn(w, "R1");
        idle(2);
        check_drained("R1");

        // R2 R4 R5 R6: nested divergence on warp 0
        split(0, 'hF, 'h3, 'h100, "R2");
        split(0, 'h3, 'h1, 'h200, "R6");
        split(0, 'h1, 'h1, 'h300, "R7");       // full stack: refused
        jn(0, "R4");                            // else 2 @200
        jn(0, "R5");                            // rejoin 3
        jn(0, "R6");                            // else C @100
        jn(0, "R5");                            // rejoin F
        jn(0, "R9");                            // empty: silent
        idle(2);
        check_drained("R9");

        // R3: uniform true and uniform false
        split(1, 'h5, 'hF, 'h10, "R3");
        split(1, 'h6, 'h9, 'h20, "R3");
        jn(1, "R3");
        jn(1, "R3");

        // R10: split and join together, different warps
        split(1, 'hF, 'hF, 'h30, "R3");
        step(1, 2, 'hF, 'h5, 'h300, 1, 1, "R10", "R10");
        // R10: same warp, join dropped
        step(1, 2, 'h5, 'h1, 'h400, 1, 2, "R10", "R10");
        jn(2, "R10");
        jn(2, "R10");
        jn(2, "R6");
        jn(2, "R6");
        jn(2, "R9");
        idle(2);
        check_drained("R10");

        // R7 R8: warp 3 fills, warp 2 unaffected
        split(3, 'h3, 'h3, 'h40, "R8");
        split(3, 'h3, 'h0, 'h41, "R8");
        split(3, 'hC, 'hC, 'h42, "R8");
        split(3, 'hF, 'h1, 'h43, "R7");         // one free, needs two
        split(2, 'hF, 'h2, 'h500, "R8");
        split(2, 'hD, 'h4, 'h600, "R8");
        split(3, 'h8, 'h8, 'h44, "R7");         // one free, needs one
        split(3, 'h8, 'h8, 'h45, "R7");         // now full
        jn(3, "R7");
        jn(2, "R8");
        jn(3, "R7");
        jn(2, "R8");
        jn(2, "R8");
        jn(2, "R8");
        idle(2);
        check_drained("R8");

        // R1: reset with non-empty stacks empties them
        split(1, 'hF, 'h6, 'h700, "R2");
        split(3, 'h3, 'h1, 'h800, "R2");
        idle(2);
        do_reset();
        jn(1, "R1");
        jn(3, "R1");
        jn(0, "R1");
        idle(3);
        check_drained("R1");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule